// File: doc/BRIEF.md
# Security configuration register with privilege-checked access

This block holds the 32-bit word that sets a processor's security state and trap controls. That word covers several things: the Secure or Non-secure flag, where IRQ, FIQ and external aborts are routed, mask overrides, the early-termination disable, enables for the monitor and hypervisor calls, the secure-fetch restriction, the wait-instruction traps and the error-record trap. Software reaches the register through a coprocessor-style port. Each request carries the requester's exception level (0 to 3), its security state and the hypervisor control inputs that the access check needs.

Every request is judged by a fixed decision chain. Level 3 is always granted. Levels 0 and 2 get an undefined-instruction outcome. Level 1 walks a prioritised list that can trap to level 2, to a 32-bit hypervisor mode or to level 3, each with syndrome code 0x03. When nothing in the list matches, level 1 also gets an undefined-instruction outcome. An accepted write is masked so that reserved bits stay zero. While the hypervisor's TGE input is set, a write that would raise the Non-secure flag from 0 to 1 leaves that flag at 0. The outcome and the read data come back one clock after the request, and the current register value is always visible on a separate output.

Top module: `sec_cfg_reg`

## Requirements
- R1: After a synchronous reset every bit of `cfg_o` is 0 and `rsp_valid` is 0.
- R2: A request at level 3 (`req_el`=3) returns `rsp_ok`=1. A read returns the current register value on `rsp_rdata`. A write loads the writable bits from `req_wdata`, and `rsp_rdata` is 0 for a write.
- R3: Bits 31:16, 14, 11 and 10 always read as 0 and ignore writes. Bits 0 to 9, 12, 13 and 15 are writable, so the writable mask is 0x0000B3FF.
- R4: A request at level 0 or level 2 returns `rsp_undef`=1, with `rsp_trap`=0 and `rsp_syndrome`=0.
- R5: At level 1, hypervisor trap bit `hyp_t1` has the highest priority when level 2 is enabled. With level 2 in 64-bit form the target code is 1. With level 2 in 32-bit form the target code is 2. In both cases the syndrome is 0x03.
- R6: At level 1 with no T1 trap, a Secure request (`req_nonsecure`=0) traps to level 2 (target 1) if level 2 is enabled in 64-bit form. Otherwise it traps to level 3 (target 3) if level 3 is 64-bit. The syndrome is 0x03 in both cases.
- R7: A level-1 request that matches none of the trap conditions returns `rsp_undef`=1.
- R8: A refused write leaves every register bit unchanged, and any refused request returns `rsp_rdata`=0.
- R9: While `hyp_tge`=1, an accepted write with bit 0 set leaves bit 0 at 0 if it was 0; the other writable bits are still written. Clearing bit 0, or writing 1 when it is already 1, is unaffected.
- R10: Each request produces exactly one response, in the following cycle, with exactly one of `rsp_ok`, `rsp_undef`, `rsp_trap` set. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_el | input | 2 | Exception level of the requester |
| req_nonsecure | input | 1 | Requester security state, 1 = Non-secure |
| hyp_el2_en | input | 1 | Level 2 is enabled |
| hyp_el2_is64 | input | 1 | Level 2 uses the 64-bit form |
| mon_el3_is64 | input | 1 | Level 3 uses the 64-bit form |
| hyp_t1 | input | 1 | Hypervisor trap bit for this register group |
| hyp_tge | input | 1 | Hypervisor general-exception routing bit |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | Access completed |
| rsp_undef | output | 1 | Undefined-instruction outcome |
| rsp_trap | output | 1 | Trap to a higher level |
| rsp_trap_target | output | 2 | 1 = level 2 (64-bit), 2 = 32-bit hypervisor mode, 3 = level 3, 0 = none |
| rsp_syndrome | output | 8 | Syndrome code, 0x03 on a trap, else 0 |
| rsp_rdata | output | 32 | Read data, 0 unless an accepted read |
| cfg_o | output | 32 | Current register contents |

## Verification
Masking of reserved bits and suppression of the Non-secure flag act in the same clock edge when TGE is set. The bench provokes this by writing all ones at level 3 from a cleared register. It expects 0x0000B3FE, with every writable bit set except bit 0 and the reserved bits still zero. A separate case writes all ones while bit 0 is already 1, to show that the suppression applies only to the 0-to-1 transition.

// File: rtl/sec_cfg_pkg.sv
package sec_cfg_pkg;

  localparam int CFG_W = 32;

  // field positions that neighbouring logic decodes
  localparam int F_NS   = 0;
  localparam int F_HCE  = 8;
  localparam int F_TWI  = 12;
  localparam int F_TWE  = 13;
  localparam int F_TERR = 15;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_EL2  = 2'd1,
    TGT_HYP  = 2'd2,
    TGT_EL3  = 2'd3
  } trap_tgt_e;

  typedef struct packed {
    logic      ok;
    logic      undef;
    logic      trap;
    trap_tgt_e tgt;
  } verdict_t;

  function automatic logic [CFG_W-1:0] cfg_writable(input bit has_el2, input bit has_err);
    logic [CFG_W-1:0] m;
    m         = '0;
    m[9:0]    = '1;
    m[F_HCE]  = has_el2;
    m[F_TWI]  = 1'b1;
    m[F_TWE]  = 1'b1;
    m[F_TERR] = has_err;
    return m;
  endfunction

endpackage

// File: rtl/sec_cfg_access_check.sv
module sec_cfg_access_check
  import sec_cfg_pkg::*;
#(
  parameter bit HAS_EL2 = 1'b1
) (
  input  logic [1:0] el,
  input  logic       nonsecure,
  input  logic       el2_en,
  input  logic       el2_is64,
  input  logic       el3_is64,
  input  logic       t1,
  output verdict_t   verdict
);

  logic el2_a64;
  logic el2_a32;

  generate
    if (HAS_EL2) begin : g_el2
      assign el2_a64 = el2_en &  el2_is64;
      assign el2_a32 = el2_en & ~el2_is64;
    end else begin : g_no_el2
      logic unused_el2;
      assign unused_el2 = el2_en ^ el2_is64;
      assign el2_a64 = 1'b0;
      assign el2_a32 = 1'b0;
    end
  endgenerate

  always_comb begin
    verdict = '0;
    unique case (el)
      2'd3: verdict.ok = 1'b1;
      2'd1: begin
        if (el2_a64 && t1) begin
          verdict.trap = 1'b1;
          verdict.tgt  = TGT_EL2;
        end else if (el2_a32 && t1) begin
          verdict.trap = 1'b1;
          verdict.tgt  = TGT_HYP;
        end else if (el2_a64 && !nonsecure) begin
          verdict.trap = 1'b1;
          verdict.tgt  = TGT_EL2;
        end else if (el3_is64 && !nonsecure) begin
          verdict.trap = 1'b1;
          verdict.tgt  = TGT_EL3;
        end else begin
          verdict.undef = 1'b1;
        end
      end
      default: verdict.undef = 1'b1;
    endcase
  end

endmodule

// File: rtl/sec_cfg_store.sv
module sec_cfg_store #(
  parameter int             W      = 32,
  parameter logic [W-1:0]   MASK   = '1,
  parameter int             NS_IDX = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         tge,
  output logic [W-1:0] cfg_q
);

  logic [W-1:0] nxt;
  logic         ns_block;

  assign ns_block = tge & ~cfg_q[NS_IDX] & wdata[NS_IDX];

  always_comb begin
    nxt = wdata & MASK;
    if (ns_block) nxt[NS_IDX] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= '0;
    else if (wr_en) cfg_q <= nxt;
  end

  // R9: a TGE-gated write never raises the non-secure flag
  a_r9_tge_holds_ns: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tge && !cfg_q[NS_IDX]) |=> !cfg_q[NS_IDX]);

  // R3: bits outside the mask never become set
  a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((cfg_q & ~MASK) == '0));

endmodule

// File: rtl/sec_cfg_reg.sv
module sec_cfg_reg
  import sec_cfg_pkg::*;
#(
  parameter bit               HAS_EL2     = 1'b1,
  parameter bit               HAS_ERR_REC = 1'b1,
  parameter int               SYN_W       = 8,
  parameter logic [SYN_W-1:0] TRAP_CODE   = 'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CFG_W-1:0] req_wdata,
  input  logic [1:0]       req_el,
  input  logic             req_nonsecure,
  input  logic             hyp_el2_en,
  input  logic             hyp_el2_is64,
  input  logic             mon_el3_is64,
  input  logic             hyp_t1,
  input  logic             hyp_tge,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic             rsp_undef,
  output logic             rsp_trap,
  output logic [1:0]       rsp_trap_target,
  output logic [SYN_W-1:0] rsp_syndrome,
  output logic [CFG_W-1:0] rsp_rdata,
  output logic [CFG_W-1:0] cfg_o
);

  localparam logic [CFG_W-1:0] WR_MASK = cfg_writable(HAS_EL2, HAS_ERR_REC);

  verdict_t         verdict;
  logic             wr_en;
  logic [CFG_W-1:0] cfg_q;

  sec_cfg_access_check #(.HAS_EL2(HAS_EL2)) u_check (
    .el        (req_el),
    .nonsecure (req_nonsecure),
    .el2_en    (hyp_el2_en),
    .el2_is64  (hyp_el2_is64),
    .el3_is64  (mon_el3_is64),
    .t1        (hyp_t1),
    .verdict   (verdict)
  );

  assign wr_en = req_valid & req_write & verdict.ok;

  sec_cfg_store #(.W(CFG_W), .MASK(WR_MASK), .NS_IDX(F_NS)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wdata (req_wdata),
    .tge   (hyp_tge),
    .cfg_q (cfg_q)
  );

  assign cfg_o = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_ok          <= 1'b0;
      rsp_undef       <= 1'b0;
      rsp_trap        <= 1'b0;
      rsp_trap_target <= '0;
      rsp_syndrome    <= '0;
      rsp_rdata       <= '0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_ok          <= req_valid & verdict.ok;
      rsp_undef       <= req_valid & verdict.undef;
      rsp_trap        <= req_valid & verdict.trap;
      rsp_trap_target <= req_valid ? verdict.tgt : 2'd0;
      rsp_syndrome    <= (req_valid && verdict.trap) ? TRAP_CODE : '0;
      rsp_rdata       <= (req_valid && verdict.ok && !req_write) ? cfg_q : '0;
    end
  end

  // R10: one response per request, one cycle later
  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r10_single_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($countones({rsp_ok, rsp_undef, rsp_trap}) == 1));

  // R4: levels 0 and 2 are always undefined
  a_r4_low_levels_undef: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_el == 2'd0 || req_el == 2'd2)) |=> rsp_undef);

  // R5/R6: traps carry the fixed syndrome
  a_r6_trap_syndrome: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_syndrome == TRAP_CODE && rsp_trap_target != 2'd0));

  // R8: refused writes leave the register alone, refused reads give zero
  a_r8_refused_stable: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !verdict.ok) |=> $stable(cfg_q));
  a_r8_refused_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ok) |-> (rsp_rdata == '0));

endmodule

// File: tb/sec_cfg_reg_test.sv
module sec_cfg_reg_test;

  localparam logic [31:0] MASK = 32'h0000_B3FF;

  typedef struct packed {
    logic        ok;
    logic        undef;
    logic        trap;
    logic [1:0]  tgt;
    logic [7:0]  syn;
    logic [31:0] rdata;
    logic [31:0] cfg;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_el = '0;
  logic        req_nonsecure = 1'b0;
  logic        hyp_el2_en = 1'b0;
  logic        hyp_el2_is64 = 1'b0;
  logic        mon_el3_is64 = 1'b0;
  logic        hyp_t1 = 1'b0;
  logic        hyp_tge = 1'b0;
  logic        rsp_valid, rsp_ok, rsp_undef, rsp_trap;
  logic [1:0]  rsp_trap_target;
  logic [7:0]  rsp_syndrome;
  logic [31:0] rsp_rdata, cfg_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  logic [31:0] ref_cfg = '0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  sec_cfg_reg uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wdata(req_wdata), .req_el(req_el), .req_nonsecure(req_nonsecure),
    .hyp_el2_en(hyp_el2_en), .hyp_el2_is64(hyp_el2_is64),
    .mon_el3_is64(mon_el3_is64), .hyp_t1(hyp_t1), .hyp_tge(hyp_tge),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_undef(rsp_undef),
    .rsp_trap(rsp_trap), .rsp_trap_target(rsp_trap_target),
    .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata), .cfg_o(cfg_o)
  );

  task automatic send(input logic [1:0] el, input logic wr, input logic [31:0] wd,
                      input logic ns, input logic e2, input logic e2_64,
                      input logic e3_64, input logic t1, input logic tge,
                      input string tag);
    exp_t e;
    logic [31:0] nv;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = wd; req_el = el;
    req_nonsecure = ns; hyp_el2_en = e2; hyp_el2_is64 = e2_64;
    mon_el3_is64 = e3_64; hyp_t1 = t1; hyp_tge = tge;
    e = '0;
    if (el == 2'd3) begin
      e.ok = 1'b1;
      if (wr) begin
        nv = wd & MASK;
        if (tge && !ref_cfg[0] && wd[0]) nv[0] = 1'b0;
        ref_cfg = nv;
      end else begin
        e.rdata = ref_cfg;
      end
    end else if (el == 2'd1) begin
      if (e2 && e2_64 && t1)            begin e.trap = 1'b1; e.tgt = 2'd1; end
      else if (e2 && !e2_64 && t1)      begin e.trap = 1'b1; e.tgt = 2'd2; end
      else if (e2 && e2_64 && !ns)      begin e.trap = 1'b1; e.tgt = 2'd1; end
      else if (e3_64 && !ns)            begin e.trap = 1'b1; e.tgt = 2'd3; end
      else                              e.undef = 1'b1;
      if (e.trap) e.syn = 8'h03;
    end else begin
      e.undef = 1'b1;
    end
    e.cfg = ref_cfg;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done && rsp_valid) begin
      exp_t  e;
      exp_t  a;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10: response without request, actual valid=1 expected valid=0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {rsp_ok, rsp_undef, rsp_trap, rsp_trap_target, rsp_syndrome, rsp_rdata, cfg_o};
        if (a !== e) begin
          errors++;
          $display("FAIL %s: actual ok=%b undef=%b trap=%b tgt=%0d syn=%h rdata=%h cfg=%h expected ok=%b undef=%b trap=%b tgt=%0d syn=%h rdata=%h cfg=%h",
                   t, a.ok, a.undef, a.trap, a.tgt, a.syn, a.rdata, a.cfg,
                   e.ok, e.undef, e.trap, e.tgt, e.syn, e.rdata, e.cfg);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R10: watchdog expired, actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (cfg_o !== 32'h0 || rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual cfg=%h valid=%b expected cfg=00000000 valid=0", cfg_o, rsp_valid);
    end
    //    el  wr  wdata          ns e2 64 e3 t1 tge
    send(3, 0, 32'h0,          0, 0, 0, 0, 0, 0, "R2");
    send(3, 1, 32'hFFFF_FFFF,  0, 0, 0, 0, 0, 0, "R3");
    send(3, 0, 32'h0,          0, 0, 0, 0, 0, 0, "R3");
    idle(2);
    send(0, 1, 32'h0,          1, 1, 1, 1, 0, 0, "R4");
    send(2, 0, 32'h0,          1, 1, 1, 1, 0, 0, "R4");
    send(2, 1, 32'h0,          0, 1, 1, 1, 1, 0, "R8");
    send(1, 1, 32'h0,          1, 1, 1, 1, 1, 0, "R5");
    send(1, 0, 32'h0,          1, 1, 0, 1, 1, 0, "R5");
    send(1, 0, 32'h0,          0, 1, 0, 1, 1, 0, "R5");
    send(1, 1, 32'h0,          0, 1, 1, 1, 0, 0, "R6");
    send(1, 0, 32'h0,          0, 0, 1, 1, 1, 0, "R6");
    send(1, 0, 32'h0,          0, 1, 0, 1, 0, 0, "R6");
    send(1, 1, 32'h0,          0, 1, 0, 0, 0, 0, "R7");
    send(1, 0, 32'h0,          1, 1, 1, 1, 0, 0, "R7");
    send(1, 0, 32'h0,          1, 0, 0, 0, 1, 0, "R7");
    send(3, 0, 32'h0,          1, 0, 0, 0, 0, 0, "R8");
    idle(1);
    send(3, 1, 32'h0,          0, 0, 0, 0, 0, 0, "R2");
    send(3, 1, 32'h0000_0001,  0, 0, 0, 0, 0, 1, "R9");
    send(3, 1, 32'hFFFF_FFFF,  0, 0, 0, 0, 0, 1, "R9");
    send(3, 1, 32'h0000_0001,  0, 0, 0, 0, 0, 0, "R2");
    send(3, 1, 32'hFFFF_FFFF,  0, 0, 0, 0, 0, 1, "R9");
    send(3, 1, 32'h0000_0000,  0, 0, 0, 0, 0, 1, "R9");
    send(3, 1, 32'h0000_4C00,  0, 0, 0, 0, 0, 0, "R3");
    send(3, 0, 32'h0,          0, 0, 0, 0, 0, 0, "R3");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d responses missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule